// File: doc/BRIEF.md
# Hardware Stack and Subroutine Sequencer

This block owns the 8-bit stack pointer of a small 8-bit processor with a 16-bit address bus. It carries out the byte-wide memory traffic for four stack commands: push a byte, pull a byte, call a subroutine and return from one. All stack traffic goes to one fixed 256-byte page, and the stack pointer selects the byte within that page. A push stores the byte and then moves the pointer down. A pull moves the pointer up and then reads.

A command is presented on `cmdValid` together with the current program counter, a call target and a data byte. The sequencer drives a synchronous single-port memory. Read data comes back on the cycle after the address is presented. The block holds `busy` while it works and pulses `done` once the command has completed. A call saves the program counter minus one, high byte first, and then jumps to the target. A return restores that saved value and adds one to it. A separate input loads the stack pointer directly, as a register transfer would.

Top module: `stack_sequencer`

## Requirements
- R1: Push (`cmdOp`=0) writes `cmdData` to address {0x01, sp}. The stack pointer then decrements by one modulo 256, so 0x00 becomes 0xFF with no error.
- R2: Pull (`cmdOp`=1) first increments the stack pointer modulo 256, so 0xFF becomes 0x00. It then reads {0x01, sp}, and `pullData` shows the byte read.
- R3: Call (`cmdOp`=2) writes bits 15:8 of (`cmdPc` − 1) mod 65536 at {0x01, sp} and bits 7:0 at {0x01, sp−1}. It leaves sp lower by two and sets `pcOut` to `cmdTarget`.
- R4: Return (`cmdOp`=3) reads the low byte at {0x01, sp+1} and the high byte at {0x01, sp+2}. It leaves sp higher by two and sets `pcOut` to (value + 1) mod 65536.
- R5: Each memory byte access takes one cycle. `done` is high for exactly one cycle, a fixed number of rising edges after the edge that accepts the command, counting that edge: push 2, pull 4, call 3, return 5.
- R6: `busy` is high from the edge that accepts a command until the cycle after `done`. A command or stack-pointer load presented while `busy` is high is ignored.
- R7: After reset, the stack pointer is 0xFF, `pcOut` is 0, `pullData` is 0, and `busy`, `done` and `memWe` are low.
- R8: While idle, `spLoad` sets the stack pointer to `spLoadVal` at the next edge. If `cmdValid` is also high in that cycle, the load wins and the command is not accepted.
- R9: Push and pull leave `pcOut` unchanged. `pullData` and `pcOut` hold their values between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command request, sampled while idle |
| cmdOp | input | 2 | 0 push, 1 pull, 2 call, 3 return |
| cmdPc | input | 16 | Current program counter for a call |
| cmdTarget | input | 16 | Call destination |
| cmdData | input | 8 | Byte to push |
| spLoad | input | 1 | Direct stack pointer load request |
| spLoadVal | input | 8 | Value for the direct load |
| memRdata | input | 8 | Memory read data, one cycle after the address |
| memAddr | output | 16 | Memory address, always inside the stack page |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| spOut | output | 8 | Current stack pointer |
| pullData | output | 8 | Last byte pulled |
| pcOut | output | 16 | Program counter after call or return |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A stack pointer stepped the wrong way or at the wrong moment shows up as a misplaced byte in the memory model as soon as the next write lands. It also shows as a wrong `spOut` in the `done` cycle of that command. A wrong state sequence moves `done` away from its fixed latency, or it makes a return reassemble bytes from the wrong slots, so `pcOut` is wrong one cycle after the final read. Commands that leak through while `busy` is high produce an extra `done` or a changed stack pointer within a few cycles of the first command finishing.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_PULL = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stackOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic spInc;
    logic spDec;
    logic memWr;
    logic selHi;
    logic selLo;
    logic capLo;
    logic capPull;
    logic setTarget;
    logic setReturn;
    logic spLoadEn;
  } stackCtl_t;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic [1:0] cmdOp,
  input  logic      spLoad,
  output stackCtl_t ctl,
  output logic      busy,
  output logic      done
);

  typedef enum logic [3:0] {
    S_IDLE, S_PUSH,
    S_PULL_INC, S_PULL_RD, S_PULL_CAP,
    S_CALL_HI, S_CALL_LO,
    S_RET_INC, S_RET_LO, S_RET_HI, S_RET_CAP,
    S_DONE
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (spLoad) begin
          ctl.spLoadEn = 1'b1;
        end else if (cmdValid) begin
          ctl.latchCmd = 1'b1;
          unique case (stackOp_e'(cmdOp))
            OP_PUSH: stateNxt = S_PUSH;
            OP_PULL: stateNxt = S_PULL_INC;
            OP_CALL: stateNxt = S_CALL_HI;
            OP_RET:  stateNxt = S_RET_INC;
          endcase
        end
      end
      S_PUSH: begin
        ctl.memWr = 1'b1;
        ctl.spDec = 1'b1;
        stateNxt  = S_DONE;
      end
      S_PULL_INC: begin
        ctl.spInc = 1'b1;
        stateNxt  = S_PULL_RD;
      end
      S_PULL_RD:  stateNxt = S_PULL_CAP;
      S_PULL_CAP: begin
        ctl.capPull = 1'b1;
        stateNxt    = S_DONE;
      end
      S_CALL_HI: begin
        ctl.memWr = 1'b1;
        ctl.selHi = 1'b1;
        ctl.spDec = 1'b1;
        stateNxt  = S_CALL_LO;
      end
      S_CALL_LO: begin
        ctl.memWr     = 1'b1;
        ctl.selLo     = 1'b1;
        ctl.spDec     = 1'b1;
        ctl.setTarget = 1'b1;
        stateNxt      = S_DONE;
      end
      S_RET_INC: begin
        ctl.spInc = 1'b1;
        stateNxt  = S_RET_LO;
      end
      S_RET_LO: begin
        ctl.spInc = 1'b1;
        stateNxt  = S_RET_HI;
      end
      S_RET_HI: begin
        ctl.capLo = 1'b1;
        stateNxt  = S_RET_CAP;
      end
      S_RET_CAP: begin
        ctl.setReturn = 1'b1;
        stateNxt      = S_DONE;
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ctl.memWr); // R6

endmodule

// File: rtl/stack_seq_dpath.sv
module stack_seq_dpath
  import stack_seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [DATA_W-1:0] SP_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCtl_t         ctl,
  input  logic [ADDR_W-1:0] cmdPc,
  input  logic [ADDR_W-1:0] cmdTarget,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] spLoadVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] pullData,
  output logic [ADDR_W-1:0] pcOut
);

  localparam int HALF_W = ADDR_W / 2;

  logic [DATA_W-1:0] sp;
  logic [ADDR_W-1:0] pcReg, retAddr, tgtReg;
  logic [DATA_W-1:0] datReg, loByte, pullReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp      <= SP_RESET;
      pcReg   <= '0;
      retAddr <= '0;
      tgtReg  <= '0;
      datReg  <= '0;
      loByte  <= '0;
      pullReg <= '0;
    end else begin
      if (ctl.spLoadEn)   sp <= spLoadVal;
      else if (ctl.spInc) sp <= sp + 1'b1;
      else if (ctl.spDec) sp <= sp - 1'b1;
      if (ctl.latchCmd) begin
        retAddr <= cmdPc - 1'b1;
        tgtReg  <= cmdTarget;
        datReg  <= cmdData;
      end
      if (ctl.capLo)   loByte  <= memRdata;
      if (ctl.capPull) pullReg <= memRdata;
      if (ctl.setTarget)      pcReg <= tgtReg;
      else if (ctl.setReturn) pcReg <= {memRdata, loByte} + 1'b1;
    end
  end

  always_comb begin
    if (ctl.selHi)      memWdata = retAddr[ADDR_W-1:HALF_W];
    else if (ctl.selLo) memWdata = retAddr[HALF_W-1:0];
    else                memWdata = datReg;
  end

  assign memAddr  = {STACK_PAGE, sp};
  assign memWe    = ctl.memWr;
  assign spOut    = sp;
  assign pullData = pullReg;
  assign pcOut    = pcReg;

  AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.spInc && ctl.spDec)); // R1

endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [DATA_W-1:0] SP_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdPc,
  input  logic [ADDR_W-1:0] cmdTarget,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              spLoad,
  input  logic [DATA_W-1:0] spLoadVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] pullData,
  output logic [ADDR_W-1:0] pcOut,
  output logic              busy,
  output logic              done
);

  stackCtl_t ctl;

  stack_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .spLoad   (spLoad),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  stack_seq_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .SP_RESET   (SP_RESET)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmdPc     (cmdPc),
    .cmdTarget (cmdTarget),
    .cmdData   (cmdData),
    .spLoadVal (spLoadVal),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .spOut     (spOut),
    .pullData  (pullData),
    .pcOut     (pcOut)
  );

  AST_WRITE_DECREMENTS: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(spOut) - 1'b1); // R1

  AST_PC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(pcOut)); // R9

  AST_SP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !spLoad) |=> $stable(spOut)); // R8

  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(pullData)); // R9

endmodule

// File: tb/sim_stack_sequencer.sv
module sim_stack_sequencer;

  localparam logic [1:0] OPC_PUSH = 2'd0, OPC_PULL = 2'd1, OPC_CALL = 2'd2, OPC_RET = 2'd3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, spLoad = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [15:0] cmdPc = '0, cmdTarget = '0;
  logic [7:0] cmdData = '0, spLoadVal = '0;
  logic [7:0] memRdata;
  logic [15:0] memAddr, pcOut;
  logic [7:0] memWdata, spOut, pullData;
  logic memWe, busy, done;

  always #4 clk = ~clk; // 125 MHz

  stack_sequencer u0 (.*);

  logic [7:0] pageMem [256];
  always @(posedge clk) begin
    if (memWe) pageMem[memAddr[7:0]] <= memWdata;
    memRdata <= pageMem[memAddr[7:0]];
  end

  int checks = 0, errors = 0, cycleCnt = 0;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    int issue;
    int lat;
    logic [7:0] sp;
    logic [15:0] pc;
    logic [7:0] pd;
    int nw;
    logic [7:0] a0, v0, a1, v1;
  } exp_t;

  exp_t q[$];
  logic [7:0] refSp = 8'hFF, refPd = 8'h00;
  logic [15:0] refPc = 16'h0000;
  logic [7:0] refStk [256];

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && memWe) check("R1 page", {24'd0, memAddr[15:8]}, 32'h01);
    if (rstN && done) begin
      if (q.size() == 0) begin
        check("R6 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " latency"}, cycleCnt - e.issue, e.lat);
        check({e.tag, " sp"}, {24'd0, spOut}, {24'd0, e.sp});
        check({e.tag, " pc"}, {16'd0, pcOut}, {16'd0, e.pc});
        check({e.tag, " pullData"}, {24'd0, pullData}, {24'd0, e.pd});
        if (e.nw > 0) check({e.tag, " byte0"}, {24'd0, pageMem[e.a0]}, {24'd0, e.v0});
        if (e.nw > 1) check({e.tag, " byte1"}, {24'd0, pageMem[e.a1]}, {24'd0, e.v1});
      end
    end
  end

  // driver: computes expectations from the requirements
  task automatic doCmd(logic [1:0] op, logic [15:0] pc, logic [15:0] tgt,
                       logic [7:0] d, bit poke);
    exp_t e;
    logic [15:0] r;
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    e.nw = 0; e.a0 = '0; e.v0 = '0; e.a1 = '0; e.v1 = '0;
    case (op)
      OPC_PUSH: begin // R1
        e.tag = "R1 push"; e.lat = 2;
        refStk[refSp] = d; e.nw = 1; e.a0 = refSp; e.v0 = d;
        refSp = refSp - 8'd1;
      end
      OPC_PULL: begin // R2
        e.tag = "R2 pull"; e.lat = 4;
        refSp = refSp + 8'd1; refPd = refStk[refSp];
      end
      OPC_CALL: begin // R3
        e.tag = "R3 call"; e.lat = 3;
        r = pc - 16'd1;
        refStk[refSp] = r[15:8]; e.nw = 2; e.a0 = refSp; e.v0 = r[15:8];
        refSp = refSp - 8'd1;
        refStk[refSp] = r[7:0]; e.a1 = refSp; e.v1 = r[7:0];
        refSp = refSp - 8'd1;
        refPc = tgt;
      end
      default: begin // R4
        e.tag = "R4 return"; e.lat = 5;
        refSp = refSp + 8'd1; r[7:0] = refStk[refSp];
        refSp = refSp + 8'd1; r[15:8] = refStk[refSp];
        refPc = r + 16'd1;
      end
    endcase
    e.sp = refSp; e.pc = refPc; e.pd = refPd; e.issue = cycleCnt;
    q.push_back(e);
    cmdValid = 1'b1; cmdOp = op; cmdPc = pc; cmdTarget = tgt; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R6 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      @(negedge clk); // R6: requests while busy are ignored
      cmdValid = 1'b1; cmdOp = OPC_PUSH; cmdData = 8'hEE;
      spLoad = 1'b1; spLoadVal = 8'h55;
      @(negedge clk);
      cmdValid = 1'b0; spLoad = 1'b0;
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 sp", {24'd0, spOut}, 32'hFF);
    check("R7 pc", {16'd0, pcOut}, 32'h0);
    check("R7 pullData", {24'd0, pullData}, 32'h0);
    check("R7 busy/done/we", {29'd0, busy, done, memWe}, 32'h0);
    rstN = 1'b1;

    doCmd(OPC_PUSH, 16'h0, 16'h0, 8'hA5, 0);
    doCmd(OPC_PUSH, 16'h0, 16'h0, 8'h3C, 0);
    doCmd(OPC_PULL, 16'h0, 16'h0, 8'h00, 0);
    doCmd(OPC_PULL, 16'h0, 16'h0, 8'h00, 0);
    waitIdle();

    // R8: direct load, then wrap on push and pull
    spLoad = 1'b1; spLoadVal = 8'h01;
    @(negedge clk); spLoad = 1'b0; refSp = 8'h01;
    check("R8 direct load", {24'd0, spOut}, 32'h01);
    doCmd(OPC_PUSH, 16'h0, 16'h0, 8'h11, 0);
    doCmd(OPC_PUSH, 16'h0, 16'h0, 8'h22, 0); // R1 wrap 00 -> FF
    doCmd(OPC_PULL, 16'h0, 16'h0, 8'h00, 0); // R2 wrap FF -> 00
    doCmd(OPC_PULL, 16'h0, 16'h0, 8'h00, 0);

    doCmd(OPC_CALL, 16'h1234, 16'h8000, 8'h00, 0);
    doCmd(OPC_RET,  16'h0, 16'h0, 8'h00, 0);
    doCmd(OPC_CALL, 16'h0000, 16'h4000, 8'h00, 0); // R3 pc-1 wraps
    doCmd(OPC_RET,  16'h0, 16'h0, 8'h00, 0);       // R4 +1 wraps
    doCmd(OPC_CALL, 16'h0200, 16'h0300, 8'h00, 0);
    doCmd(OPC_CALL, 16'h0310, 16'h0400, 8'h00, 0);
    doCmd(OPC_PUSH, 16'h0, 16'h0, 8'h77, 0);       // R9 pc held
    doCmd(OPC_PULL, 16'h0, 16'h0, 8'h00, 0);
    doCmd(OPC_RET,  16'h0, 16'h0, 8'h00, 0);
    doCmd(OPC_RET,  16'h0, 16'h0, 8'h00, 0);

    // R6: push and load presented mid-call are ignored
    doCmd(OPC_CALL, 16'hABCD, 16'h5000, 8'h00, 1);
    waitIdle();
    repeat (6) @(negedge clk);
    check("R6 no extra command", {31'd0, busy}, 32'd0);
    check("R6 sp unchanged", {24'd0, spOut}, {24'd0, refSp});

    // R8: load wins over a simultaneous command
    spLoad = 1'b1; spLoadVal = 8'h80; cmdValid = 1'b1; cmdOp = OPC_PUSH;
    @(negedge clk);
    spLoad = 1'b0; cmdValid = 1'b0; refSp = 8'h80;
    check("R8 load priority sp", {24'd0, spOut}, 32'h80);
    @(negedge clk);
    check("R8 command dropped", {31'd0, busy}, 32'd0);
    doCmd(OPC_PUSH, 16'h0, 16'h0, 8'h5A, 0);
    doCmd(OPC_PULL, 16'h0, 16'h0, 8'h00, 0);
    waitIdle();
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule